// File: doc/BRIEF.md
# SPI Slave Transaction and Receive-Idle Timeout Monitor

This block runs beside an SPI controller and raises a timeout flag for two unrelated stall conditions. The first is a per-transaction watchdog for slave operation: once the select line is active and the first serial clock edge of the transaction has arrived, an engine-clock counter runs. If it reaches a programmable 16-bit limit before the controller reports the transaction finished, a sticky slave timeout is recorded. Software clears it by writing one.

The second condition is a receive-idle watchdog. While the receive FIFO holds data that nobody reads, a counter advances. In master mode it advances once per SPI clock period, marked by a tick input. In slave mode it advances on every engine clock. When it reaches 64 ticks in master mode or 576 engine clocks in slave mode, the receive timeout status goes high. That status drops by itself as soon as the FIFO is read or becomes empty.

Both conditions are combined into one timeout flag for the controller's interrupt logic.

Top module: `spi_tmo_monitor`

## Requirements
- R1: After reset, `slv_tmo_o`, `rx_tmo_o` and `tmo_flag_o` are all 0.
- R2: With select active (`sel_active_i`=1) and a nonzero limit, the slave counter does not run and no slave timeout occurs until a one-cycle pulse on `sclk_edge_i` has been sampled.
- R3: After the clock edge that samples the first `sclk_edge_i` pulse with select active and limit L>0, `slv_tmo_o` rises at the L-th following rising clock edge, provided select stays active, `xfer_done_i` stays 0 and the limit is unchanged. The count saturates at 65535.
- R4: A sampled `xfer_done_i`=1 or `sel_active_i`=0 clears the slave counter and disarms it, so that no timeout follows until a new `sclk_edge_i` pulse arrives.
- R5: A limit of 0 on `slv_limit_i` clears and disarms the slave counter and prevents any new slave timeout.
- R6: `slv_tmo_o` stays 1 until a cycle with `slv_flag_clr_i`=1 and no new slave timeout in that same cycle. A new timeout in the clearing cycle wins, and the flag stays 1.
- R7: In master mode (`master_mode_i`=1), while `rx_not_empty_i`=1 with no read, each `spi_tick_i` pulse advances the idle count. `rx_tmo_o` rises one clock after the edge that samples the 64th tick.
- R8: In slave mode (`master_mode_i`=0), the idle count advances on every clock. `rx_tmo_o` rises one clock after the count reaches 576.
- R9: A sampled `rx_read_i`=1 clears `rx_tmo_o` and restarts the idle count at 0 at that edge. This takes priority over setting.
- R10: A sampled `rx_not_empty_i`=0 clears `rx_tmo_o` and restarts the idle count at 0.
- R11: `tmo_flag_o` is 1 exactly when `slv_tmo_o` or `rx_tmo_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Engine clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_mode_i | input | 1 | 1 = master mode, 0 = slave mode |
| sel_active_i | input | 1 | Slave select is in its active state |
| sclk_edge_i | input | 1 | One-cycle pulse per serial clock edge |
| xfer_done_i | input | 1 | Pulse when a transaction completes |
| slv_limit_i | input | 16 | Slave timeout limit in engine clocks, 0 disables |
| spi_tick_i | input | 1 | One pulse per SPI clock period (master mode) |
| rx_not_empty_i | input | 1 | Receive FIFO holds data |
| rx_read_i | input | 1 | Receive FIFO read strobe |
| slv_flag_clr_i | input | 1 | Write-one clear of the slave timeout flag |
| slv_tmo_o | output | 1 | Sticky slave transaction timeout |
| rx_tmo_o | output | 1 | Receive-idle timeout status |
| tmo_flag_o | output | 1 | Combined timeout flag |

## Verification
Two things can land on the same clock. A slave timeout can set in the very cycle that software writes one to clear the slave flag. The receive status can also be cleared by a FIFO read while the slave flag is being set or held. Both cases are provoked on purpose. A limit of 1 keeps the slave counter hitting every cycle while the clear strobe is raised. Separately, a FIFO read is issued while the slave flag holds. A long random phase then mixes strobes, ticks and mode changes. Every cycle, each output is compared with a behavioural model that applies set-wins-over-clear for the slave flag and read-wins-over-set for the receive status.

// File: rtl/spi_tmo_pkg.sv
package spi_tmo_pkg;
  localparam int unsigned LIMIT_W_DEF  = 16;
  localparam int unsigned MST_IDLE_DEF = 64;
  localparam int unsigned SLV_IDLE_DEF = 576;

  typedef enum logic {
    MODE_SLAVE  = 1'b0,
    MODE_MASTER = 1'b1
  } spi_mode_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/slv_tmo_counter.sv
module slv_tmo_counter #(
  parameter int unsigned LIMIT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sel_active_i,
  input  logic               sclk_edge_i,
  input  logic               xfer_done_i,
  input  logic [LIMIT_W-1:0] limit_i,
  output logic               hit_o
);
  logic [LIMIT_W-1:0] cnt_q;
  logic               arm_q;
  logic               disarm;

  assign disarm = !sel_active_i || xfer_done_i || (limit_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else if (disarm) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else if (arm_q || sclk_edge_i) begin
      arm_q <= 1'b1;
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end
  end

  // hit only while the transaction is still open
  assign hit_o = arm_q && !disarm && (cnt_q >= limit_i);
endmodule

// File: rtl/rx_idle_counter.sv
module rx_idle_counter
  import spi_tmo_pkg::*;
#(
  parameter int unsigned MST_IDLE = 64,
  parameter int unsigned SLV_IDLE = 576
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  spi_mode_e mode_i,
  input  logic      tick_i,
  input  logic      not_empty_i,
  input  logic      read_i,
  output logic      tmo_o
);
  localparam int unsigned MAX_IDLE = max_u(MST_IDLE, SLV_IDLE);
  localparam int unsigned CW       = $clog2(MAX_IDLE + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          adv;
  logic          tmo_q;

  assign lim = (mode_i == MODE_MASTER) ? CW'(MST_IDLE) : CW'(SLV_IDLE);
  assign adv = (mode_i == MODE_MASTER) ? tick_i : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (!not_empty_i || read_i) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else begin
      if (cnt_q >= lim) tmo_q <= 1'b1;
      if (adv && (cnt_q < lim)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tmo_o = tmo_q;
endmodule

// File: rtl/tmo_sticky_flag.sv
module tmo_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set beats clear so a coincident event is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/spi_tmo_monitor.sv
module spi_tmo_monitor
  import spi_tmo_pkg::*;
#(
  parameter int unsigned LIMIT_W  = LIMIT_W_DEF,
  parameter int unsigned MST_IDLE = MST_IDLE_DEF,
  parameter int unsigned SLV_IDLE = SLV_IDLE_DEF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               master_mode_i,
  input  logic               sel_active_i,
  input  logic               sclk_edge_i,
  input  logic               xfer_done_i,
  input  logic [LIMIT_W-1:0] slv_limit_i,
  input  logic               spi_tick_i,
  input  logic               rx_not_empty_i,
  input  logic               rx_read_i,
  input  logic               slv_flag_clr_i,
  output logic               slv_tmo_o,
  output logic               rx_tmo_o,
  output logic               tmo_flag_o
);
  spi_mode_e mode;
  logic      slv_hit;

  assign mode = master_mode_i ? MODE_MASTER : MODE_SLAVE;

  slv_tmo_counter #(.LIMIT_W(LIMIT_W)) u_slv_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_active_i (sel_active_i),
    .sclk_edge_i  (sclk_edge_i),
    .xfer_done_i  (xfer_done_i),
    .limit_i      (slv_limit_i),
    .hit_o        (slv_hit)
  );

  tmo_sticky_flag u_slv_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (slv_hit),
    .clr_i  (slv_flag_clr_i),
    .flag_o (slv_tmo_o)
  );

  rx_idle_counter #(.MST_IDLE(MST_IDLE), .SLV_IDLE(SLV_IDLE)) u_rx_idle (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .tick_i      (spi_tick_i),
    .not_empty_i (rx_not_empty_i),
    .read_i      (rx_read_i),
    .tmo_o       (rx_tmo_o)
  );

  assign tmo_flag_o = slv_tmo_o | rx_tmo_o;
endmodule

// File: rtl/spi_tmo_monitor_chk.sv
module spi_tmo_monitor_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sel_active_i,
  input logic xfer_done_i,
  input logic limit_zero_i,
  input logic rx_not_empty_i,
  input logic rx_read_i,
  input logic slv_flag_clr_i,
  input logic slv_tmo_i,
  input logic rx_tmo_i,
  input logic tmo_flag_i
);
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !tmo_flag_i); // R1

  AST_NO_SET_WITHOUT_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_active_i && !slv_tmo_i |=> !slv_tmo_i); // R2

  AST_RISE_INSIDE_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slv_tmo_i) |-> $past(sel_active_i) && !$past(xfer_done_i)); // R4

  AST_ZERO_LIMIT_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limit_zero_i && !slv_tmo_i |=> !slv_tmo_i); // R5

  AST_SLV_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slv_tmo_i && !slv_flag_clr_i |=> slv_tmo_i); // R6

  AST_RX_RISE_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_tmo_i) |-> $past(rx_not_empty_i) && !$past(rx_read_i)); // R7

  AST_READ_CLEARS_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_read_i |=> !rx_tmo_i); // R9

  AST_EMPTY_CLEARS_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_not_empty_i |=> !rx_tmo_i); // R10

  AST_FLAG_COVERS_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_tmo_i |-> tmo_flag_i); // R11
endmodule

bind spi_tmo_monitor spi_tmo_monitor_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sel_active_i   (sel_active_i),
  .xfer_done_i    (xfer_done_i),
  .limit_zero_i   (slv_limit_i == '0),
  .rx_not_empty_i (rx_not_empty_i),
  .rx_read_i      (rx_read_i),
  .slv_flag_clr_i (slv_flag_clr_i),
  .slv_tmo_i      (slv_tmo_o),
  .rx_tmo_i       (rx_tmo_o),
  .tmo_flag_i     (tmo_flag_o)
);

// File: tb/spi_tmo_monitor_tb.sv
`timescale 1ns/1ps
module spi_tmo_monitor_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        master = 1'b0, sel = 1'b0, sedge = 1'b0, done = 1'b0;
  logic [15:0] limit = 16'd0;
  logic        tick = 1'b0, ne = 1'b0, rd = 1'b0, clr = 1'b0;
  logic        slv_tmo, rx_tmo, flag;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_tmo_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .master_mode_i(master), .sel_active_i(sel),
    .sclk_edge_i(sedge), .xfer_done_i(done), .slv_limit_i(limit),
    .spi_tick_i(tick), .rx_not_empty_i(ne), .rx_read_i(rd),
    .slv_flag_clr_i(clr), .slv_tmo_o(slv_tmo), .rx_tmo_o(rx_tmo), .tmo_flag_o(flag)
  );

  // behavioural reference
  int m_scnt = 0, m_rcnt = 0;
  bit m_arm = 0, m_sflag = 0, m_rflag = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_scnt = 0; m_arm = 0; m_sflag = 0; m_rcnt = 0; m_rflag = 0;
    end else begin
      bit stop, hit;
      int lim;
      stop = !sel || done || (limit == 0);
      hit  = m_arm && !stop && (m_scnt >= int'(limit));
      if (stop) begin
        m_scnt = 0; m_arm = 0;
      end else if (m_arm || sedge) begin
        m_arm = 1;
        if (m_scnt < 65535) m_scnt++;
      end
      if (hit) m_sflag = 1;
      else if (clr) m_sflag = 0;
      lim = master ? 64 : 576;
      if (!ne || rd) begin
        m_rcnt = 0; m_rflag = 0;
      end else begin
        if (m_rcnt >= lim) m_rflag = 1;
        if ((master ? tick : 1'b1) && m_rcnt < lim) m_rcnt++;
      end
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      n_cmp++;
      if (slv_tmo !== m_sflag || rx_tmo !== m_rflag || flag !== (m_sflag | m_rflag)) begin
        n_bad++;
        $display("FAIL model R3/R7/R11 t=%0t slv=%b/%b rx=%b/%b flag=%b/%b (act/exp)",
                 $time, slv_tmo, m_sflag, rx_tmo, m_rflag, flag, m_sflag | m_rflag);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_edge();
    sedge = 1'b1; cyc(1); sedge = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    cyc(3);
    chk("R1 slv", slv_tmo, 1'b0);
    chk("R1 rx", rx_tmo, 1'b0);
    chk("R1 flag", flag, 1'b0);
    rst_n = 1'b1;
    cyc(2);

    // R2: select active, no serial edge
    sel = 1'b1; limit = 16'd5;
    cyc(20);
    chk("R2 no edge no timeout", slv_tmo, 1'b0);

    // R3: limit 5
    pulse_edge();
    cyc(4);
    chk("R3 before limit", slv_tmo, 1'b0);
    cyc(1);
    chk("R3 at limit", slv_tmo, 1'b1);

    // R6: sticky, then clear
    sel = 1'b0; cyc(10);
    chk("R6 sticky", slv_tmo, 1'b1);
    clr = 1'b1; cyc(1); clr = 1'b0;
    chk("R6 cleared", slv_tmo, 1'b0);
    sel = 1'b1; limit = 16'd1;
    pulse_edge();
    cyc(1);
    chk("R6 set with limit 1", slv_tmo, 1'b1);
    clr = 1'b1; cyc(1); clr = 1'b0;
    chk("R6 set wins over clear", slv_tmo, 1'b1);
    sel = 1'b0; cyc(1);
    clr = 1'b1; cyc(1); clr = 1'b0;
    chk("R6 clear when idle", slv_tmo, 1'b0);

    // R4: done and deselect clear the count
    sel = 1'b1; limit = 16'd8;
    pulse_edge(); cyc(3);
    done = 1'b1; cyc(1); done = 1'b0;
    cyc(15);
    chk("R4 done disarms", slv_tmo, 1'b0);
    pulse_edge(); cyc(3);
    sel = 1'b0; cyc(1); sel = 1'b1;
    cyc(15);
    chk("R4 deselect disarms", slv_tmo, 1'b0);

    // R5: limit 0 disarms
    limit = 16'd3;
    pulse_edge();
    limit = 16'd0; cyc(1); limit = 16'd3;
    cyc(10);
    chk("R5 zero limit disarms", slv_tmo, 1'b0);
    limit = 16'd0; pulse_edge(); cyc(10);
    chk("R5 zero limit never fires", slv_tmo, 1'b0);
    sel = 1'b0;

    // R7: master mode, 64 ticks
    master = 1'b1; ne = 1'b1;
    for (int i = 0; i < 63; i++) begin
      tick = 1'b1; cyc(1); tick = 1'b0; cyc(2);
    end
    chk("R7 after 63 ticks", rx_tmo, 1'b0);
    tick = 1'b1; cyc(1); tick = 1'b0;
    chk("R7 count reached 64", rx_tmo, 1'b0);
    cyc(1);
    chk("R7 fires", rx_tmo, 1'b1);
    chk("R11 flag from rx", flag, 1'b1);

    // R9: read clears
    rd = 1'b1; cyc(1); rd = 1'b0;
    chk("R9 read clears", rx_tmo, 1'b0);
    cyc(5);
    chk("R9 count restarted", rx_tmo, 1'b0);
    chk("R11 flag low", flag, 1'b0);

    // R11 with slave flag held during rx activity
    sel = 1'b1; limit = 16'd1; pulse_edge(); cyc(1); sel = 1'b0;
    chk("R11 flag from slave", flag, 1'b1);

    // R8: slave mode, 576 clocks
    master = 1'b0;
    rd = 1'b1; cyc(1); rd = 1'b0;
    cyc(576);
    chk("R8 at 576 not yet", rx_tmo, 1'b0);
    cyc(1);
    chk("R8 fires", rx_tmo, 1'b1);
    rd = 1'b1; cyc(1); rd = 1'b0;
    chk("R9 read in slave mode", rx_tmo, 1'b0);
    chk("R11 slave flag keeps flag", flag, 1'b1);
    clr = 1'b1; cyc(1); clr = 1'b0;

    // R10: empty resets count
    cyc(400);
    ne = 1'b0; cyc(1);
    chk("R10 empty no status", rx_tmo, 1'b0);
    ne = 1'b1; cyc(400);
    chk("R10 count restarted on empty", rx_tmo, 1'b0);
    cyc(200);
    chk("R10 fires after full window", rx_tmo, 1'b1);
    ne = 1'b0; cyc(1);
    chk("R10 empty clears status", rx_tmo, 1'b0);

    // random mix, checked by the model every cycle
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 99) == 0) master = ~master;
      if ($urandom_range(0, 24) == 0) sel = ~sel;
      if ($urandom_range(0, 49) == 0) limit = 16'($urandom_range(0, 12));
      sedge = ($urandom_range(0, 2) == 0);
      done  = ($urandom_range(0, 19) == 0);
      tick  = ($urandom_range(0, 3) == 0);
      ne    = ($urandom_range(0, 199) != 0);
      rd    = ($urandom_range(0, 599) == 0);
      clr   = ($urandom_range(0, 29) == 0);
      cyc(1);
    end
    sedge = 1'b0; done = 1'b0; tick = 1'b0; rd = 1'b0; clr = 1'b0;
    cyc(2);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end
endmodule